// File: doc/BRIEF.md
# MESI Snooping Cache Controller

This block is the coherence controller of one private cache sitting on an atomic snooping bus. It keeps a small direct-mapped array of lines, each holding a one-word block, a tag and a four-state coherence code (Invalid, Shared, Exclusive, Modified). It serves processor reads, writes and explicit replacements. It issues bus reads, read-for-ownership, ownership upgrades and write-backs. It also watches the transactions that other caches place on the bus and reacts to them.

A read miss samples the wired-OR shared line one cycle after the bus accepts the request, which is the address phase. The line is then committed in Shared or Exclusive when the fill data arrives. A write to an Exclusive line becomes Modified with no bus traffic. On the snoop side the controller raises the shared line for blocks it holds. It flushes dirty data, and it demotes or invalidates its copy. When the C2C_EN parameter is set, it also supplies clean data in place of memory, unless a fixed-priority input says a lower-indexed cache has already claimed the supply.

Processor requests and responses use valid/ready. A request is taken only while `cpu_req_ready` is high. A response stays valid with stable data until `cpu_rsp_ready` is sampled high. A bus request stays valid with a stable command until `bus_req_ready` grants it. The one exception is a cycle in which a snoop is present: the request is then withdrawn and re-evaluated. The bus is atomic. No snoop arrives between a grant and the completion of that transaction, and fill data is accepted only while a fill is pending.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, `cpu_req_ready` is 1, and `bus_req_valid` and `cpu_rsp_valid` are 0. A snoop then asserts none of the snoop outputs.
- R2: A read miss issues command 0 (read) for the request address. The shared line is sampled in the cycle after the grant. The line fills as Shared if the shared line was 1 and as Exclusive if it was 0, and the response returns the fill data.
- R3: A read that hits a Shared, Exclusive or Modified line issues no bus request and returns the stored word.
- R4: A write that hits an Exclusive or Modified line issues no bus request and leaves the line Modified with the new word.
- R5: A write that hits a Shared line issues command 2 (upgrade), takes no fill data, and leaves the line Modified with the written word.
- R6: A write miss issues command 1 (read-for-ownership), waits for the fill, and leaves the line Modified holding the written word.
- R7: A snooped command 0 to a held line raises `snp_shared_o` in the same cycle. Exclusive becomes Shared. Modified becomes Shared and raises `snp_flush_o` with the line word on `snp_data_o`.
- R8: A snooped command 1 or 2 to a held line invalidates it, and a Modified line is flushed in that cycle. A snoop whose tag does not match leaves the line and outputs untouched.
- R9: Replacing a Modified line issues command 3 (write-back) with the line address and word, and the line becomes Invalid. Replacing a Shared or Exclusive line is silent, and replacing an absent line has no effect. Operation codes are 0 read, 1 write, 2 replace, and 3 is a reserved no-op.
- R10: A miss to a set whose resident line of another tag is Modified first writes that line back with command 3, then issues the miss command. A clean resident line is dropped silently.
- R11: With C2C_EN set, a Shared or Exclusive holder raises `snp_supply_o` with its word on a snooped command 0 or 1 unless `snp_prio_i` is 1. With C2C_EN clear it never supplies. Flush and supply are never raised together.
- R12: The bus command is chosen from the live line state. A write to a Shared line that is invalidated by a snoop before its grant issues command 1 instead of command 2.
- R13: A response holds valid and data until accepted. A bus request holds valid until granted, except in a cycle with a snoop.
- R14: A snoop takes precedence. While `snp_valid` is 1, the controller neither requests the bus nor updates a line from the processor side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request valid |
| cpu_req_ready | output | 1 | Controller can take a request |
| cpu_req_op | input | 2 | 0 read, 1 write, 2 replace, 3 no-op |
| cpu_req_addr | input | ADDR_W | Block address |
| cpu_req_wdata | input | DATA_W | Write word |
| cpu_rsp_valid | output | 1 | Response valid |
| cpu_rsp_ready | input | 1 | Processor takes the response |
| cpu_rsp_rdata | output | DATA_W | Read word (reads only) |
| bus_req_valid | output | 1 | Bus transaction requested |
| bus_req_ready | input | 1 | Bus grant |
| bus_req_cmd | output | 2 | 0 read, 1 read-for-ownership, 2 upgrade, 3 write-back |
| bus_req_addr | output | ADDR_W | Transaction address |
| bus_req_data | output | DATA_W | Write-back word |
| bus_shared_i | input | 1 | Wired-OR shared line |
| bus_fill_valid | input | 1 | Fill data present |
| bus_fill_data | input | DATA_W | Fill word |
| snp_valid | input | 1 | Another cache's transaction in its address phase |
| snp_cmd | input | 2 | Snooped command, same codes as bus_req_cmd |
| snp_addr | input | ADDR_W | Snooped address |
| snp_prio_i | input | 1 | A lower-indexed cache already supplies |
| snp_shared_o | output | 1 | Drive onto the shared line |
| snp_flush_o | output | 1 | Dirty data driven for memory and requester |
| snp_supply_o | output | 1 | Clean data driven instead of memory |
| snp_data_o | output | DATA_W | Flush or supply word |

## Verification
The bench sets up an Exclusive line by a fill with the shared line low and a Shared line by a fill with it high. A following write tells the two apart: a design that ignored the sampled shared line would upgrade an Exclusive line or silently dirty a Shared one. A write that waits for the bus while a snoop invalidates its Shared line must switch from upgrade to read-for-ownership. A design that latched the command at decision time would claim ownership of a block it no longer holds. Dirty-victim misses must emit the write-back before the fill. A design that skipped it would lose the Modified word. Snoops with a matching index but a foreign tag, and supply requests blocked by the priority input, must leave the line and the data outputs unchanged.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

  typedef enum logic [1:0] {
    LN_I = 2'd0,
    LN_S = 2'd1,
    LN_E = 2'd2,
    LN_M = 2'd3
  } line_st_e;

  typedef enum logic [1:0] {
    BC_RD   = 2'd0,
    BC_RDX  = 2'd1,
    BC_UPGR = 2'd2,
    BC_WB   = 2'd3
  } bus_cmd_e;

  typedef enum logic [1:0] {
    OP_RD  = 2'd0,
    OP_WR  = 2'd1,
    OP_RPL = 2'd2,
    OP_NOP = 2'd3
  } cpu_op_e;

endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
  import mesi_pkg::*;
#(
  parameter int SETS   = 8,
  parameter int TAG_W  = 5,
  parameter int DATA_W = 32,
  localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  // processor-side port
  input  logic [IDX_W-1:0]  cpu_idx,
  output line_st_e          cpu_state,
  output logic [TAG_W-1:0]  cpu_tag,
  output logic [DATA_W-1:0] cpu_data,
  input  logic              cpu_we,
  input  line_st_e          cpu_wstate,
  input  logic [TAG_W-1:0]  cpu_wtag,
  input  logic              cpu_wdata_en,
  input  logic [DATA_W-1:0] cpu_wdata,
  // snoop-side port
  input  logic [IDX_W-1:0]  snp_idx,
  output line_st_e          snp_state,
  output logic [TAG_W-1:0]  snp_tag,
  output logic [DATA_W-1:0] snp_data,
  input  logic              snp_we,
  input  line_st_e          snp_wstate
);

  line_st_e          st_q   [SETS];
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [DATA_W-1:0] data_q [SETS];

  for (genvar g = 0; g < SETS; g++) begin : g_line
    logic hit_snp, hit_cpu;
    assign hit_snp = snp_we && (snp_idx == IDX_W'(g));
    assign hit_cpu = cpu_we && (cpu_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q[g]   <= LN_I;
        tag_q[g]  <= '0;
        data_q[g] <= '0;
      end else if (hit_snp) begin
        st_q[g] <= snp_wstate;
      end else if (hit_cpu) begin
        st_q[g]  <= cpu_wstate;
        tag_q[g] <= cpu_wtag;
        if (cpu_wdata_en) data_q[g] <= cpu_wdata;
      end
    end
  end

  assign cpu_state = st_q[cpu_idx];
  assign cpu_tag   = tag_q[cpu_idx];
  assign cpu_data  = data_q[cpu_idx];
  assign snp_state = st_q[snp_idx];
  assign snp_tag   = tag_q[snp_idx];
  assign snp_data  = data_q[snp_idx];

  // R14: processor-side updates never coincide with a snoop update
  assert_snoop_first_R14: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_we && snp_we));

endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
  import mesi_pkg::*;
#(
  parameter int TAG_W  = 5,
  parameter int DATA_W = 32,
  parameter bit C2C_EN = 1'b1
) (
  input  logic              snp_valid,
  input  bus_cmd_e          snp_cmd,
  input  logic [TAG_W-1:0]  snp_tag,
  input  logic              snp_prio_i,
  input  line_st_e          line_state,
  input  logic [TAG_W-1:0]  line_tag,
  input  logic [DATA_W-1:0] line_data,
  output logic              shared_o,
  output logic              flush_o,
  output logic              supply_o,
  output logic [DATA_W-1:0] data_o,
  output logic              line_we,
  output line_st_e          line_wstate
);

  logic hit, is_rd, is_inv, clean;

  assign hit    = snp_valid && (line_state != LN_I) && (line_tag == snp_tag);
  assign is_rd  = (snp_cmd == BC_RD);
  assign is_inv = (snp_cmd == BC_RDX) || (snp_cmd == BC_UPGR);
  assign clean  = (line_state == LN_S) || (line_state == LN_E);

  assign shared_o = hit && is_rd;
  assign flush_o  = hit && (line_state == LN_M) && (is_rd || is_inv);

  if (C2C_EN) begin : g_c2c
    assign supply_o = hit && clean && (is_rd || snp_cmd == BC_RDX) && !snp_prio_i;
  end else begin : g_mem_only
    logic unused_prio;
    assign unused_prio = snp_prio_i;
    assign supply_o = 1'b0;
  end

  assign data_o = (flush_o || supply_o) ? line_data : '0;

  always_comb begin
    line_we     = 1'b0;
    line_wstate = LN_S;
    if (hit && is_inv) begin
      line_we     = 1'b1;
      line_wstate = LN_I;
    end else if (hit && is_rd && line_state != LN_S) begin
      line_we     = 1'b1;
      line_wstate = LN_S;
    end
  end

endmodule

// File: rtl/mesi_req_fsm.sv
module mesi_req_fsm
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic [1:0]        cpu_req_op,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  input  logic              cpu_rsp_ready,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              bus_req_valid,
  input  logic              bus_req_ready,
  output bus_cmd_e          bus_req_cmd,
  output logic [ADDR_W-1:0] bus_req_addr,
  output logic [DATA_W-1:0] bus_req_data,
  input  logic              bus_shared_i,
  input  logic              bus_fill_valid,
  input  logic [DATA_W-1:0] bus_fill_data,
  input  logic              snp_busy_i,
  output logic [IDX_W-1:0]  line_idx_o,
  input  line_st_e          line_state_i,
  input  logic [TAG_W-1:0]  line_tag_i,
  input  logic [DATA_W-1:0] line_data_i,
  output logic              line_we_o,
  output line_st_e          line_wstate_o,
  output logic [TAG_W-1:0]  line_wtag_o,
  output logic              line_wdata_en_o,
  output logic [DATA_W-1:0] line_wdata_o
);

  typedef enum logic [2:0] {F_IDLE, F_DECIDE, F_ADDR, F_FILL, F_RESP} fsm_e;

  fsm_e              st_q, st_d;
  cpu_op_e           op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  bus_cmd_e          cmd_q, cmd_d;
  logic              shr_q;

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic              hit, dirty_victim, owns;
  logic              need_bus, loc_done, loc_we, loc_den, loc_rd;
  line_st_e          loc_state;

  assign idx          = addr_q[IDX_W-1:0];
  assign tag          = addr_q[ADDR_W-1:IDX_W];
  assign hit          = (line_state_i != LN_I) && (line_tag_i == tag);
  assign dirty_victim = (line_state_i == LN_M) && (line_tag_i != tag);
  assign owns         = (line_state_i == LN_E) || (line_state_i == LN_M);
  assign line_idx_o   = idx;

  // decision from the live line state (R12)
  always_comb begin
    need_bus  = 1'b0;
    cmd_d     = BC_RD;
    loc_done  = 1'b0;
    loc_we    = 1'b0;
    loc_den   = 1'b0;
    loc_rd    = 1'b0;
    loc_state = LN_I;
    unique case (op_q)
      OP_RD: begin
        if (hit) begin
          loc_done = 1'b1;
          loc_rd   = 1'b1;
        end else begin
          need_bus = 1'b1;
          cmd_d    = dirty_victim ? BC_WB : BC_RD;
        end
      end
      OP_WR: begin
        if (hit && owns) begin
          loc_done  = 1'b1;
          loc_we    = 1'b1;
          loc_den   = 1'b1;
          loc_state = LN_M;
        end else if (hit) begin
          need_bus = 1'b1;
          cmd_d    = BC_UPGR;
        end else begin
          need_bus = 1'b1;
          cmd_d    = dirty_victim ? BC_WB : BC_RDX;
        end
      end
      OP_RPL: begin
        if (hit && line_state_i == LN_M) begin
          need_bus = 1'b1;
          cmd_d    = BC_WB;
        end else if (hit) begin
          loc_done  = 1'b1;
          loc_we    = 1'b1;
          loc_state = LN_I;
        end else begin
          loc_done = 1'b1;
        end
      end
      default: loc_done = 1'b1;
    endcase
  end

  always_comb begin
    st_d            = st_q;
    line_we_o       = 1'b0;
    line_wstate_o   = LN_I;
    line_wtag_o     = tag;
    line_wdata_en_o = 1'b0;
    line_wdata_o    = wdata_q;
    unique case (st_q)
      F_IDLE: if (cpu_req_valid) st_d = F_DECIDE;
      F_DECIDE: begin
        if (!snp_busy_i) begin
          if (need_bus) begin
            if (bus_req_ready) st_d = F_ADDR;
          end else if (loc_done) begin
            line_we_o       = loc_we;
            line_wstate_o   = loc_state;
            line_wdata_en_o = loc_den;
            st_d            = F_RESP;
          end
        end
      end
      F_ADDR: begin
        unique case (cmd_q)
          BC_RD, BC_RDX: st_d = F_FILL;
          BC_UPGR: begin
            line_we_o       = 1'b1;
            line_wstate_o   = LN_M;
            line_wdata_en_o = 1'b1;
            st_d            = F_RESP;
          end
          default: begin
            line_we_o     = 1'b1;
            line_wstate_o = LN_I;
            st_d          = F_DECIDE;
          end
        endcase
      end
      F_FILL: begin
        if (bus_fill_valid) begin
          line_we_o       = 1'b1;
          line_wdata_en_o = 1'b1;
          if (cmd_q == BC_RD) begin
            line_wstate_o = shr_q ? LN_S : LN_E;
            line_wdata_o  = bus_fill_data;
            st_d          = F_DECIDE;
          end else begin
            line_wstate_o = LN_M;
            st_d          = F_RESP;
          end
        end
      end
      F_RESP: if (cpu_rsp_ready) st_d = F_IDLE;
      default: st_d = F_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= F_IDLE;
      op_q    <= OP_NOP;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      cmd_q   <= BC_RD;
      shr_q   <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == F_IDLE && cpu_req_valid) begin
        op_q    <= cpu_op_e'(cpu_req_op);
        addr_q  <= cpu_req_addr;
        wdata_q <= cpu_req_wdata;
      end
      if (bus_req_valid && bus_req_ready) cmd_q <= cmd_d;
      if (st_q == F_ADDR) shr_q <= bus_shared_i;
      if (st_q == F_DECIDE && !snp_busy_i && loc_rd) rdata_q <= line_data_i;
    end
  end

  assign cpu_req_ready = (st_q == F_IDLE);
  assign cpu_rsp_valid = (st_q == F_RESP);
  assign cpu_rsp_rdata = rdata_q;
  assign bus_req_valid = (st_q == F_DECIDE) && !snp_busy_i && need_bus;
  assign bus_req_cmd   = cmd_d;
  assign bus_req_addr  = (cmd_d == BC_WB) ? {line_tag_i, idx} : addr_q;
  assign bus_req_data  = line_data_i;

  // R2: fill state follows the shared line sampled in the address phase
  assert_fill_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == F_FILL && bus_fill_valid && cmd_q == BC_RD) |=>
      (line_state_i == ($past(shr_q) ? LN_S : LN_E)));

  // R4: a write to an owned line dirties it without the bus
  assert_owned_write_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == F_DECIDE && !snp_busy_i && op_q == OP_WR && hit && owns) |->
      (!bus_req_valid ##1 line_state_i == LN_M));

  // R13: bus request held until grant unless a snoop intervenes
  assert_bus_req_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && !bus_req_ready) |=> (bus_req_valid || snp_busy_i));

  // R13: response held with stable data until accepted
  assert_rsp_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rsp_valid && !cpu_rsp_ready) |=> (cpu_rsp_valid && $stable(cpu_rsp_rdata)));

endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int SETS   = 8,
  parameter bit C2C_EN = 1'b1,
  localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic [1:0]        cpu_req_op,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  input  logic              cpu_rsp_ready,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              bus_req_valid,
  input  logic              bus_req_ready,
  output logic [1:0]        bus_req_cmd,
  output logic [ADDR_W-1:0] bus_req_addr,
  output logic [DATA_W-1:0] bus_req_data,
  input  logic              bus_shared_i,
  input  logic              bus_fill_valid,
  input  logic [DATA_W-1:0] bus_fill_data,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic              snp_prio_i,
  output logic              snp_shared_o,
  output logic              snp_flush_o,
  output logic              snp_supply_o,
  output logic [DATA_W-1:0] snp_data_o
);

  logic [IDX_W-1:0]  c_idx;
  line_st_e          c_state, c_wstate, s_state, s_wstate;
  logic [TAG_W-1:0]  c_tag, c_wtag, s_tag;
  logic [DATA_W-1:0] c_data, c_wdata, s_data;
  logic              c_we, c_den, s_we;
  bus_cmd_e          req_cmd;

  mesi_line_store #(.SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk, .rst_n,
    .cpu_idx(c_idx), .cpu_state(c_state), .cpu_tag(c_tag), .cpu_data(c_data),
    .cpu_we(c_we), .cpu_wstate(c_wstate), .cpu_wtag(c_wtag),
    .cpu_wdata_en(c_den), .cpu_wdata(c_wdata),
    .snp_idx(snp_addr[IDX_W-1:0]), .snp_state(s_state), .snp_tag(s_tag),
    .snp_data(s_data), .snp_we(s_we), .snp_wstate(s_wstate)
  );

  mesi_snoop_unit #(.TAG_W(TAG_W), .DATA_W(DATA_W), .C2C_EN(C2C_EN)) u_snoop (
    .snp_valid, .snp_cmd(bus_cmd_e'(snp_cmd)), .snp_tag(snp_addr[ADDR_W-1:IDX_W]),
    .snp_prio_i, .line_state(s_state), .line_tag(s_tag), .line_data(s_data),
    .shared_o(snp_shared_o), .flush_o(snp_flush_o), .supply_o(snp_supply_o),
    .data_o(snp_data_o), .line_we(s_we), .line_wstate(s_wstate)
  );

  mesi_req_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_fsm (
    .clk, .rst_n,
    .cpu_req_valid, .cpu_req_ready, .cpu_req_op, .cpu_req_addr, .cpu_req_wdata,
    .cpu_rsp_valid, .cpu_rsp_ready, .cpu_rsp_rdata,
    .bus_req_valid, .bus_req_ready, .bus_req_cmd(req_cmd), .bus_req_addr,
    .bus_req_data, .bus_shared_i, .bus_fill_valid, .bus_fill_data,
    .snp_busy_i(snp_valid),
    .line_idx_o(c_idx), .line_state_i(c_state), .line_tag_i(c_tag),
    .line_data_i(c_data), .line_we_o(c_we), .line_wstate_o(c_wstate),
    .line_wtag_o(c_wtag), .line_wdata_en_o(c_den), .line_wdata_o(c_wdata)
  );

  assign bus_req_cmd = req_cmd;

  // R11: dirty flush and clean supply never drive the data together
  assert_one_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({snp_flush_o, snp_supply_o}));

  // R7: the shared line is only driven during a snooped read
  assert_shared_on_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    snp_shared_o |-> (snp_valid && snp_cmd == 2'd0));

  // R14: no bus request while a snoop is present
  assert_no_req_in_snoop_R14: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> !bus_req_valid);

endmodule

// File: tb/mesi_snoop_ctrl_tb_top.sv
module mesi_snoop_ctrl_tb_top;

  localparam int AW = 8;
  localparam int DW = 32;
  localparam logic [1:0] C_RD = 2'd0, C_RDX = 2'd1, C_UPG = 2'd2, C_WB = 2'd3;
  localparam logic [1:0] O_RD = 2'd0, O_WR = 2'd1, O_RPL = 2'd2;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          cpu_req_valid = 0, cpu_req_ready, cpu_rsp_valid, cpu_rsp_ready = 0;
  logic [1:0]    cpu_req_op = 0;
  logic [AW-1:0] cpu_req_addr = 0;
  logic [DW-1:0] cpu_req_wdata = 0, cpu_rsp_rdata;
  logic          bus_req_valid, bus_req_ready = 0, bus_shared_i = 0, bus_fill_valid = 0;
  logic [1:0]    bus_req_cmd;
  logic [AW-1:0] bus_req_addr;
  logic [DW-1:0] bus_req_data, bus_fill_data = 0;
  logic          snp_valid = 0, snp_prio_i = 0;
  logic [1:0]    snp_cmd = 0;
  logic [AW-1:0] snp_addr = 0;
  logic          snp_shared_o, snp_flush_o, snp_supply_o;
  logic [DW-1:0] snp_data_o;
  // memory-supply-only twin driven by the same stimulus
  logic          nc_req_ready, nc_rsp_valid, nc_bus_valid, nc_shared, nc_flush, nc_supply;
  logic [DW-1:0] nc_rdata, nc_bus_data, nc_sdata;
  logic [1:0]    nc_cmd;
  logic [AW-1:0] nc_addr;

  mesi_snoop_ctrl #(.C2C_EN(1'b1)) dut_i (
    .clk, .rst_n, .cpu_req_valid, .cpu_req_ready, .cpu_req_op, .cpu_req_addr,
    .cpu_req_wdata, .cpu_rsp_valid, .cpu_rsp_ready, .cpu_rsp_rdata,
    .bus_req_valid, .bus_req_ready, .bus_req_cmd, .bus_req_addr, .bus_req_data,
    .bus_shared_i, .bus_fill_valid, .bus_fill_data, .snp_valid, .snp_cmd,
    .snp_addr, .snp_prio_i, .snp_shared_o, .snp_flush_o, .snp_supply_o, .snp_data_o);

  mesi_snoop_ctrl #(.C2C_EN(1'b0)) dut_nc (
    .clk, .rst_n, .cpu_req_valid, .cpu_req_ready(nc_req_ready), .cpu_req_op,
    .cpu_req_addr, .cpu_req_wdata, .cpu_rsp_valid(nc_rsp_valid), .cpu_rsp_ready,
    .cpu_rsp_rdata(nc_rdata), .bus_req_valid(nc_bus_valid), .bus_req_ready,
    .bus_req_cmd(nc_cmd), .bus_req_addr(nc_addr), .bus_req_data(nc_bus_data),
    .bus_shared_i, .bus_fill_valid, .bus_fill_data, .snp_valid, .snp_cmd,
    .snp_addr, .snp_prio_i, .snp_shared_o(nc_shared), .snp_flush_o(nc_flush),
    .snp_supply_o(nc_supply), .snp_data_o(nc_sdata));

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  int nbus;
  logic [1:0]    lg_cmd [4];
  logic [AW-1:0] lg_addr[4];
  logic [DW-1:0] lg_data[4];
  logic [DW-1:0] rd;
  logic          s_sh, s_fl, s_su, s_nsu;
  logic [DW-1:0] s_dat;

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic launch(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] wd);
    nbus = 0;
    @(negedge clk);
    cpu_req_valid = 1; cpu_req_op = op; cpu_req_addr = a; cpu_req_wdata = wd;
    @(negedge clk);
    cpu_req_valid = 0;
  endtask

  task automatic serve(input logic shr, input logic [DW-1:0] fill, output logic [DW-1:0] r);
    bit done = 0;
    r = '0;
    for (int i = 0; i < 40 && !done; i++) begin
      if (cpu_rsp_valid) begin
        r = cpu_rsp_rdata;
        cpu_rsp_ready = 1;
        @(negedge clk);
        cpu_rsp_ready = 0;
        done = 1;
      end else if (bus_req_valid) begin
        if (nbus < 4) begin
          lg_cmd[nbus] = bus_req_cmd; lg_addr[nbus] = bus_req_addr; lg_data[nbus] = bus_req_data;
        end
        nbus++;
        bus_req_ready = 1;
        @(negedge clk);
        bus_req_ready = 0;
        bus_shared_i = shr;
        @(negedge clk);
        bus_shared_i = 0;
        if (lg_cmd[nbus-1] == C_RD || lg_cmd[nbus-1] == C_RDX) begin
          bus_fill_valid = 1; bus_fill_data = fill;
          @(negedge clk);
          bus_fill_valid = 0;
        end
      end else begin
        @(negedge clk);
      end
    end
    if (!done) check("serve-timeout", 0, 1);
  endtask

  task automatic access(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                        input logic shr, input logic [DW-1:0] fill);
    launch(op, a, wd);
    serve(shr, fill, rd);
  endtask

  task automatic snoop(input logic [1:0] c, input logic [AW-1:0] a, input logic prio);
    @(negedge clk);
    snp_valid = 1; snp_cmd = c; snp_addr = a; snp_prio_i = prio;
    #1;
    s_sh = snp_shared_o; s_fl = snp_flush_o; s_su = snp_supply_o;
    s_dat = snp_data_o; s_nsu = nc_supply;
    @(negedge clk);
    snp_valid = 0; snp_prio_i = 0;
  endtask

  task automatic t_reset;
    check("R1 req_ready", cpu_req_ready, 1);
    check("R1 bus_req_valid", bus_req_valid, 0);
    check("R1 rsp_valid", cpu_rsp_valid, 0);
    snoop(C_RD, 8'h10, 0);
    check("R1 snoop idle", {s_sh, s_fl, s_su}, 0);
  endtask

  task automatic t_exclusive_path;
    access(O_RD, 8'h11, 0, 0, 32'hA1);
    check("R2 one bus op", nbus, 1);
    check("R2 cmd read", lg_cmd[0], C_RD);
    check("R2 addr", lg_addr[0], 8'h11);
    check("R2 rdata", rd, 32'hA1);
    access(O_RD, 8'h11, 0, 0, 0);
    check("R3 hit no bus", nbus, 0);
    check("R3 hit data", rd, 32'hA1);
    access(O_WR, 8'h11, 32'hB2, 0, 0);
    check("R4 E write no bus", nbus, 0);
    access(O_RD, 8'h11, 0, 0, 0);
    check("R4 M data", rd, 32'hB2);
    snoop(C_RD, 8'h11, 0);
    check("R7 shared", s_sh, 1);
    check("R7 flush M", s_fl, 1);
    check("R7 flush data", s_dat, 32'hB2);
    check("R11 dirty not supply", s_su, 0);
    access(O_WR, 8'h11, 32'hC3, 0, 0);
    check("R5 upgrade after demote", {nbus[1:0], lg_cmd[0]}, {2'd1, C_UPG});
    access(O_RD, 8'h11, 0, 0, 0);
    check("R5 written data", rd, 32'hC3);
  endtask

  task automatic t_shared_fill;
    access(O_RD, 8'h22, 0, 1, 32'h55);
    check("R2 shared fill data", rd, 32'h55);
    snoop(C_RD, 8'h22, 0);
    check("R11 supply", {s_sh, s_fl, s_su}, 3'b101);
    check("R11 supply data", s_dat, 32'h55);
    check("R11 no supply when disabled", s_nsu, 0);
    snoop(C_RD, 8'h22, 1);
    check("R11 priority blocks supply", {s_sh, s_su}, 2'b10);
    access(O_WR, 8'h22, 32'h56, 0, 0);
    check("R2 S fill then upgrade", {nbus[1:0], lg_cmd[0]}, {2'd1, C_UPG});
  endtask

  task automatic t_write_miss_and_inval;
    access(O_WR, 8'h33, 32'h44, 0, 32'h99);
    check("R6 cmd rdx", {nbus[1:0], lg_cmd[0]}, {2'd1, C_RDX});
    access(O_RD, 8'h33, 0, 0, 0);
    check("R6 holds write data", {nbus[1:0], rd[7:0]}, {2'd0, 8'h44});
    snoop(C_RDX, 8'h33, 0);
    check("R8 flush on rdx", {s_sh, s_fl, s_su}, 3'b010);
    check("R8 flush data", s_dat, 32'h44);
    access(O_RD, 8'h33, 0, 0, 32'h44);
    check("R8 invalidated -> miss", {nbus[1:0], lg_cmd[0]}, {2'd1, C_RD});
    snoop(C_RDX, 8'h43, 0);
    check("R8 foreign tag ignored", {s_sh, s_fl, s_su}, 0);
    access(O_RD, 8'h33, 0, 0, 0);
    check("R8 line kept", {nbus[1:0], rd[7:0]}, {2'd0, 8'h44});
    snoop(C_UPG, 8'h33, 0);
    check("R8 upgrade no data", {s_fl, s_su}, 0);
    access(O_RD, 8'h33, 0, 0, 32'h44);
    check("R8 upgrade invalidates", nbus, 1);
  endtask

  task automatic t_replace;
    access(O_WR, 8'h33, 32'h66, 0, 0);
    access(O_RPL, 8'h33, 0, 0, 0);
    check("R9 wb cmd", {nbus[1:0], lg_cmd[0]}, {2'd1, C_WB});
    check("R9 wb addr", lg_addr[0], 8'h33);
    check("R9 wb data", lg_data[0], 32'h66);
    access(O_RD, 8'h33, 0, 0, 32'h66);
    check("R9 invalid after wb", nbus, 1);
    access(O_RPL, 8'h33, 0, 0, 0);
    check("R9 clean replace silent", nbus, 0);
    access(O_RD, 8'h33, 0, 0, 32'h66);
    check("R9 clean replace invalidates", nbus, 1);
    access(O_RPL, 8'h05, 0, 0, 0);
    check("R9 absent replace", nbus, 0);
  endtask

  task automatic t_victim;
    access(O_WR, 8'h14, 32'h77, 0, 0);
    access(O_RD, 8'h24, 0, 0, 32'h88);
    check("R10 two bus ops", nbus, 2);
    check("R10 victim wb first", {lg_cmd[0], lg_addr[0]}, {C_WB, 8'h14});
    check("R10 victim data", lg_data[0], 32'h77);
    check("R10 then read", {lg_cmd[1], lg_addr[1]}, {C_RD, 8'h24});
    check("R10 rdata", rd, 32'h88);
    access(O_RD, 8'h34, 0, 0, 32'h99);
    check("R10 clean victim silent", {nbus[1:0], lg_cmd[0]}, {2'd1, C_RD});
  endtask

  task automatic t_race;
    access(O_RD, 8'h25, 0, 1, 32'h10);
    launch(O_WR, 8'h25, 32'h31);
    check("R5 upgrade requested", {bus_req_valid, bus_req_cmd}, {1'b1, C_UPG});
    @(negedge clk);
    check("R13 request held", bus_req_valid, 1);
    snp_valid = 1; snp_cmd = C_RDX; snp_addr = 8'h25;
    #1;
    check("R14 no request during snoop", bus_req_valid, 0);
    @(negedge clk);
    snp_valid = 0;
    #1;
    check("R12 re-chosen as rdx", {bus_req_valid, bus_req_cmd}, {1'b1, C_RDX});
    serve(0, 32'h00, rd);
    access(O_RD, 8'h25, 0, 0, 0);
    check("R12 write landed", {nbus[1:0], rd[7:0]}, {2'd0, 8'h31});
  endtask

  task automatic t_rsp_hold;
    launch(O_RD, 8'h11, 0);
    for (int i = 0; i < 4 && !cpu_rsp_valid; i++) @(negedge clk);
    check("R13 rsp valid", cpu_rsp_valid, 1);
    @(negedge clk);
    check("R13 rsp held", {cpu_rsp_valid, cpu_req_ready}, 2'b10);
    check("R13 rsp data stable", cpu_rsp_rdata, 32'hC3);
    cpu_rsp_ready = 1;
    @(negedge clk);
    cpu_rsp_ready = 0;
    check("R13 back to idle", cpu_req_ready, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_exclusive_path();
    t_shared_fill();
    t_write_miss_and_inval();
    t_replace();
    t_victim();
    t_race();
    t_rsp_hold();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule